// File: doc/BRIEF.md
# PCI Base Address Register Bank

This block holds the six base address registers of one PCI function's configuration header, together with the address decoder that those registers drive. Configuration accesses arrive as a dword offset, four byte enables and write data. Reads return the addressed register one cycle later. Software finds out how large each region is by writing all ones and reading back a mask. It then writes a base address, and from that point the block decodes an incoming bus address against that window.

Each register's region size (a power of two) and its space type (I/O or memory) are fixed by parameters. The read-only low bits of a register always show the space type. The decoder keeps a separate stored base and a valid flag per register, so that a zero write or a sizing write does not disturb a window that is already open. The decoder outputs a registered hit flag and the index of the matching register.

Top module: `pci_bar_bank`

## Requirements
- R1: Reset clears every stored base and every valid flag. Each register then reads its type code only: 0x00000001 for an I/O register and 0x00000000 for a memory register. bus_hit reads 0.
- R2: Register i sits at dword offset 4+i (offsets 4 to 9). A read strobe returns that register on cfg_rdata in the next cycle. A read of any other offset returns 0xFFFFFFFF.
- R3: A write with all four byte enables set and data 0xFFFFFFFF is a sizing write. The register then reads the inverse of (size-1), OR-ed with its type code. The stored base and the valid flag do not change.
- R4: The low bits always read back the type code. For I/O this is bits [1:0] = 01. For memory it is bits [3:0] = 0000. This holds whatever value is written.
- R5: In any other write, each byte with its enable set takes the written byte, and each other byte keeps its old value. The low bits are then forced to the type code as in R4.
- R6: Take the merged value of R5 with its low type bits cleared. If that value is nonzero, it becomes the stored base and the register becomes valid. The first such write opens the window. Each later such write moves the window to the new base and keeps the same size.
- R7: If the merged value of R5 with its low type bits cleared is zero, the register reads its type code only. The stored base and the valid flag do not change, so an open window keeps decoding at its old base.
- R8: The decoder matches register i when it is valid and bus_addr[31:log2(size)] equals its stored base in those bits. The result appears on bus_hit and bus_idx one cycle after bus_addr. When several registers match, the lowest index wins. When nothing matches, bus_idx is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_dw | input | 6 | Configuration dword offset |
| cfg_be | input | 4 | Write byte enables, bit n selects byte n |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, valid the cycle after cfg_rd |
| bus_addr | input | 32 | Address to decode |
| bus_hit | output | 1 | Some valid window contains bus_addr (registered) |
| bus_idx | output | 3 | Index of the lowest matching register (registered) |

## Verification
A corrupted register shows up at cfg_rdata in the cycle after it is read back. A wrong type bit or a wrong size mask is therefore exposed by one sizing write followed by one read. A stored base or valid flag that is wrong never appears on the configuration port. It shows up only through bus_hit and bus_idx, one cycle after an address is presented. For that reason the bench probes window edges (the base, base+size-1, base+size) after zero writes, sizing writes and window moves. It also tests overlapping windows, where a wrong priority order appears as the wrong index.

// File: rtl/pci_bar_bank.sv
module pci_bar_bank #(
  parameter int              NBAR    = 6,
  parameter int              DW0     = 4,
  parameter logic [NBAR-1:0] IO_MASK = 6'b001010,
  parameter logic [NBAR*5-1:0] LOG2SZ = {5'd16, 5'd4, 5'd2, 5'd20, 5'd8, 5'd12}
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic        cfg_rd,
  input  logic [5:0]  cfg_dw,
  input  logic [3:0]  cfg_be,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic [31:0] bus_addr,
  output logic        bus_hit,
  output logic [2:0]  bus_idx
);
  localparam int IW = (NBAR > 1) ? $clog2(NBAR) : 1;

  logic [31:0]     bar_q  [NBAR];
  logic [31:0]     base_q [NBAR];
  logic [NBAR-1:0] valid_q;
  logic [NBAR-1:0] match;

  wire [5:0] off    = cfg_dw - 6'(DW0);
  wire       in_rng = (int'(cfg_dw) >= DW0) && (int'(cfg_dw) < DW0 + NBAR);
  wire       sizing = cfg_wr && (&cfg_be) && (&cfg_wdata);

  for (genvar i = 0; i < NBAR; i++) begin : g_bar
    localparam int          L     = int'(LOG2SZ[i*5 +: 5]);
    localparam bit          IO    = IO_MASK[i];
    localparam logic [31:0] LOWM  = IO ? 32'h3 : 32'hF;
    localparam logic [31:0] TYPEC = IO ? 32'h1 : 32'h0;
    localparam logic [31:0] SZM   = 32'((64'd1 << L) - 64'd1);

    if ((IO && L < 2) || (!IO && L < 4))
      $error("region size of BAR %0d below the minimum for its space type", i);

    wire        wr_i = cfg_wr && in_rng && (off == 6'(i));
    wire [31:0] merged;
    for (genvar b = 0; b < 4; b++) begin : g_byte
      assign merged[b*8 +: 8] = cfg_be[b] ? cfg_wdata[b*8 +: 8] : bar_q[i][b*8 +: 8];
    end
    wire [31:0] newv = merged & ~LOWM;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bar_q[i]   <= TYPEC;
        base_q[i]  <= '0;
        valid_q[i] <= 1'b0;
      end else if (wr_i) begin
        if (sizing) begin
          bar_q[i] <= ~SZM | TYPEC;
        end else begin
          bar_q[i] <= newv | TYPEC;
          if (newv != '0) begin
            base_q[i]  <= newv;
            valid_q[i] <= 1'b1;
          end
        end
      end
    end

    assign match[i] = valid_q[i] && ((bus_addr & ~SZM) == (base_q[i] & ~SZM));

    p_size_keeps_base_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && sizing) |=> ($stable(base_q[i]) && $stable(valid_q[i])));

    p_type_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rd && in_rng && off == 6'(i)) |=> ((cfg_rdata & LOWM) == TYPEC));

    p_valid_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q[i] |=> valid_q[i]);

    p_zero_keeps_map_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !sizing && newv == '0) |=> ($stable(base_q[i]) && $stable(valid_q[i])));
  end

  logic [2:0] idx_d;
  always_comb begin
    idx_d = '0;
    for (int k = NBAR - 1; k >= 0; k--)
      if (match[k]) idx_d = 3'(k);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_rdata <= '0;
      bus_hit   <= 1'b0;
      bus_idx   <= '0;
    end else begin
      if (cfg_rd) cfg_rdata <= in_rng ? bar_q[off[IW-1:0]] : '1;
      bus_hit <= |match;
      bus_idx <= idx_d;
    end
  end

  p_oob_ones_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd && !in_rng) |=> (cfg_rdata == 32'hFFFF_FFFF));

  p_idle_idx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_hit |-> (bus_idx == 3'd0));

  p_hit_needs_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q == '0) |=> !bus_hit);
endmodule

// File: tb/tb_pci_bar_bank.sv
module tb_pci_bar_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [5:0]  cfg_dw = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0, bus_addr = '0;
  logic [31:0] cfg_rdata;
  logic        bus_hit;
  logic [2:0]  bus_idx;

  int errors = 0, checks = 0;
  int lg [6] = '{12, 8, 20, 2, 4, 16};
  bit iob [6] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0};
  logic [31:0] mreg [6], mbase [6];
  bit mval [6];

  always #10 clk = ~clk;

  pci_bar_bank dut (.clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_dw(cfg_dw), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .bus_addr(bus_addr), .bus_hit(bus_hit), .bus_idx(bus_idx));

  function automatic logic [31:0] szm(int i);
    return 32'((64'd1 << lg[i]) - 64'd1);
  endfunction
  function automatic logic [31:0] lowm(int i);
    return iob[i] ? 32'h3 : 32'hF;
  endfunction
  function automatic logic [31:0] tcode(int i);
    return iob[i] ? 32'h1 : 32'h0;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_wr(int dw, logic [3:0] be, logic [31:0] d);
    int i = dw - 4;
    logic [31:0] mg, nv;
    if (i < 0 || i > 5) return;
    if (be == 4'hF && d == 32'hFFFF_FFFF) begin
      mreg[i] = ~szm(i) | tcode(i);
      return;
    end
    for (int b = 0; b < 4; b++) mg[b*8 +: 8] = be[b] ? d[b*8 +: 8] : mreg[i][b*8 +: 8];
    nv = mg & ~lowm(i);
    mreg[i] = nv | tcode(i);
    if (nv != 0) begin mbase[i] = nv; mval[i] = 1'b1; end
  endtask

  task automatic wr(int dw, logic [3:0] be, logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_dw = 6'(dw); cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
    model_wr(dw, be, d);
  endtask

  task automatic rd(int dw, string tag);
    logic [31:0] exp;
    @(negedge clk);
    cfg_rd = 1'b1; cfg_dw = 6'(dw);
    @(negedge clk);
    cfg_rd = 1'b0;
    exp = (dw >= 4 && dw <= 9) ? mreg[dw-4] : 32'hFFFF_FFFF;
    chk(cfg_rdata == exp, tag, cfg_rdata, exp);
  endtask

  task automatic probe(logic [31:0] a, string tag);
    bit eh = 1'b0;
    logic [2:0] ei = '0;
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    for (int k = 5; k >= 0; k--)
      if (mval[k] && ((a & ~szm(k)) == (mbase[k] & ~szm(k)))) begin eh = 1'b1; ei = 3'(k); end
    chk(bus_hit == eh && bus_idx == ei, tag, {28'b0, bus_hit, bus_idx}, {28'b0, eh, ei});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    for (int i = 0; i < 6; i++) begin mreg[i] = tcode(i); mbase[i] = 0; mval[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bus_hit == 1'b0, "R1 hit after reset", {31'b0, bus_hit}, 0);
    for (int i = 0; i < 6; i++) rd(4 + i, "R1 reset readback");
    probe(32'h0, "R1 no window after reset");

    rd(0, "R2 below range"); rd(3, "R2 below range"); rd(10, "R2 above range"); rd(63, "R2 top");

    for (int i = 0; i < 6; i++) begin
      wr(4 + i, 4'hF, 32'hFFFF_FFFF);
      rd(4 + i, "R3 sizing mask");
    end
    probe(32'h0, "R3 sizing opens no window");

    wr(4, 4'hF, 32'h8000_1000); rd(4, "R5 full write");
    probe(32'h8000_1000, "R6 window base");
    probe(32'h8000_1FFF, "R8 window top");
    probe(32'h8000_2000, "R8 just past window");
    probe(32'h8000_0FFF, "R8 just below window");

    wr(5, 4'hF, 32'h0000_C0FE); rd(5, "R4 io low bits");
    wr(8, 4'hF, 32'h1234_567F); rd(8, "R4 mem low bits");
    wr(6, 4'b0100, 32'h00AB_0000); rd(6, "R5 partial byte write");
    wr(6, 4'b0000, 32'hFFFF_FFFE); rd(6, "R5 no enables");

    wr(4, 4'hF, 32'h0000_000F); rd(4, "R7 zero base reads type");
    probe(32'h8000_1234, "R7 old window survives");
    wr(4, 4'hF, 32'hFFFF_FFFF);
    probe(32'h8000_1234, "R3 sizing keeps window");

    wr(4, 4'hF, 32'h9000_0000);
    probe(32'h8000_1234, "R6 old window closed");
    probe(32'h9000_0ABC, "R6 moved window");
    wr(9, 4'hF, 32'h9000_0000);
    probe(32'h9000_0010, "R8 overlap lowest index");
    probe(32'h9000_8000, "R8 overlap upper only");
    wr(7, 4'hF, 32'h0000_0ABC); rd(7, "R4 io minimum size");
    probe(32'h0000_0ABF, "R8 io minimum window");
    probe(32'h0000_0AC0, "R8 io minimum past");

    for (int n = 0; n < 400; n++) begin
      int op = int'($urandom % 4);
      int b = int'($urandom % 6);
      if (op == 0) begin
        logic [31:0] d = ($urandom % 5 == 0) ? 32'hFFFF_FFFF : $urandom;
        logic [3:0] be = ($urandom % 2 == 0) ? 4'hF : 4'($urandom);
        if ($urandom % 8 == 0) d = d & lowm(b);
        wr(4 + b, be, d);
      end else if (op == 1) begin
        rd(($urandom % 3 == 0) ? int'($urandom % 64) : 4 + b, "R2 random read");
      end else begin
        logic [31:0] a = $urandom;
        if (mval[b] && $urandom % 4 != 0) a = (mbase[b] & ~szm(b)) | (a & szm(b));
        probe(a, "R8 random decode");
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule